// File: doc/BRIEF.md
# Link Channel Message Transfer Engine

This block carries out the two channel message operations of a small stack machine. One strobe presents three operands: a byte count, a channel address and a start byte address. A direction bit chooses between sending and receiving. For a send, the engine reads bytes from consecutive memory addresses and presents them one at a time on an outgoing valid/ready byte stream. For a receive, it takes bytes from an incoming valid/ready stream and writes them to consecutive addresses. The link has exactly one outgoing and one incoming channel, and each has its own fixed, word-aligned address.

Memory is reached through a byte port. The read data must follow the address combinationally, and a write happens on the clock edge where the write strobe is high. Writes are gated to a configurable RAM window, so read-only memory below the window is never altered. Each operation has a minimum cost set by the word count of the message plus a fixed overhead that depends on direction. The done pulse is held back until that cost has been paid, even when the bytes themselves move faster. A start whose channel address does not match the requested direction is refused with an error pulse.

Top module: `lnk_msg_mover`

## Requirements
- R1: There is one outgoing channel at address OUT_CHAN and one incoming channel at address IN_CHAN, and both are word aligned. A start with dir_out_i=1 is accepted only when chan_i equals OUT_CHAN, and a start with dir_out_i=0 only when chan_i equals IN_CHAN. The two streams are never active in the same cycle.
- R2: On a send, byte i (counting from 0) is read from address base_i+i and presented on tx_data_o in that order. The engine moves on to the next byte only on a cycle where tx_valid_o and tx_ready_i are both high.
- R3: On a receive, the byte accepted on the i-th rx_valid_i/rx_ready_o handshake is written to address base_i+i.
- R4: Let k be the edge that accepts the start. Let MIN be 2*ceil(len/BYTES_PER_WORD)+20 for a send, or 2*ceil(len/BYTES_PER_WORD)+18 for a receive. Let L be the edge of the last byte handshake, with L=0 when there is none. Then done_o is high for exactly one cycle, and it rises at edge k+max(MIN, L+1).
- R5: mem_we_o is asserted only for addresses inside [RAM_LO, RAM_HI]. A received byte whose address falls outside that window still completes its handshake, but memory there keeps its contents.
- R6: A zero-length operation makes no handshake and raises done_o at edge k+MIN, which is k+20 for a send and k+18 for a receive.
- R7: A start with a mismatched channel address raises err_o for one cycle at the next edge. It leaves busy_o low, raises no done_o and moves no byte.
- R8: A start strobe while busy_o is high is ignored. The running operation keeps its direction and length, and no second operation follows.
- R9: After reset, busy_o, done_o, err_o, tx_valid_o, rx_ready_o and mem_we_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, sampled when idle |
| dir_out_i | input | 1 | 1 selects send, 0 selects receive |
| len_i | input | 8*BYTES_PER_WORD | Message length in bytes, unsigned |
| chan_i | input | 8*BYTES_PER_WORD | Channel address operand |
| base_i | input | 8*BYTES_PER_WORD | Start byte address |
| mem_addr_o | output | 8*BYTES_PER_WORD | Memory byte address |
| mem_rdata_i | input | 8 | Byte read at mem_addr_o (combinational) |
| mem_we_o | output | 1 | Memory byte write enable |
| mem_wdata_o | output | 8 | Byte to write |
| tx_valid_o | output | 1 | Outgoing byte valid |
| tx_ready_i | input | 1 | Outgoing byte accepted |
| tx_data_o | output | 8 | Outgoing byte |
| rx_valid_i | input | 1 | Incoming byte valid |
| rx_ready_o | output | 1 | Engine ready for incoming byte |
| rx_data_i | input | 8 | Incoming byte |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle channel mismatch pulse |

## Verification
Each result is due at a fixed edge. The first byte is offered in the cycle right after the accepting edge k. An error pulse shows at edge k+1. The done pulse shows at edge k+max(MIN, L+1). The bench counts falling edges from k, which it calls e. It records the edge e+1 of every handshake it completes, so it knows L. It then compares the falling edge where done_o is first seen against the formula, and checks that done_o is low again one edge later. Byte contents are compared against a memory image the bench computes itself once the pulse has been seen, including the bytes just past the end of the message and the bytes in the read-only part.

// File: rtl/lnk_msg_pkg.sv
package lnk_msg_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_MOVE = 1'b1
   } mover_state_e;
endpackage

// File: rtl/lnk_msg_pace.sv
// Enforces the minimum cycle cost of an operation.
module lnk_msg_pace #(
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned SEL_W   = 2,
   parameter int unsigned OVH_OUT = 20,
   parameter int unsigned OVH_IN  = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              run_i,
   input  logic              dir_out_i,
   input  logic [WORD_W-1:0] len_i,
   output logic              min_met_o
);
   localparam int unsigned CNT_W = WORD_W + 2;

   logic [WORD_W-1:0] words;
   logic [CNT_W-1:0]  target_d;
   logic [CNT_W-1:0]  target_q;
   logic [CNT_W-1:0]  elapsed_q;

   // ceil(len / bytes-per-word)
   assign words = {{SEL_W{1'b0}}, len_i[WORD_W-1:SEL_W]}
                + WORD_W'(|len_i[SEL_W-1:0]);
   assign target_d = ({2'b00, words} << 1)
                   + (dir_out_i ? CNT_W'(OVH_OUT) : CNT_W'(OVH_IN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         target_q  <= '0;
         elapsed_q <= '0;
      end else if (load_i) begin
         target_q  <= target_d;
         elapsed_q <= CNT_W'(1);
      end else if (run_i && (elapsed_q < target_q)) begin
         elapsed_q <= elapsed_q + CNT_W'(1);
      end
   end

   assign min_met_o = (elapsed_q >= target_q);

   // R4: counter saturates at the target while running
   p_elapsed_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !load_i && min_met_o) |=> (elapsed_q == target_q) || $past(load_i));
endmodule

// File: rtl/lnk_msg_cursor.sv
// Address and remaining-byte tracking for one message.
module lnk_msg_cursor #(
   parameter int unsigned WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              step_i,
   input  logic [WORD_W-1:0] base_i,
   input  logic [WORD_W-1:0] len_i,
   output logic [WORD_W-1:0] addr_o,
   output logic              empty_o
);
   logic [WORD_W-1:0] addr_q;
   logic [WORD_W-1:0] rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         rem_q  <= '0;
      end else if (load_i) begin
         addr_q <= base_i;
         rem_q  <= len_i;
      end else if (step_i) begin
         addr_q <= addr_q + WORD_W'(1);
         rem_q  <= rem_q - WORD_W'(1);
      end
   end

   assign addr_o  = addr_q;
   assign empty_o = (rem_q == '0);

   // R2: no byte moves once the message is exhausted
   p_step_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |-> !empty_o);
   // R2: each step advances the address by one
   p_step_incr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i) |=> (addr_o == $past(addr_o) + WORD_W'(1)));
endmodule

// File: rtl/lnk_msg_wrgate.sv
// Decides whether a byte write may reach memory.
module lnk_msg_wrgate #(
   parameter int unsigned      WORD_W = 32,
   parameter bit               GUARD  = 1'b1,
   parameter logic [WORD_W-1:0] RAM_LO = '0,
   parameter logic [WORD_W-1:0] RAM_HI = '1
) (
   input  logic [WORD_W-1:0] addr_i,
   output logic              allow_o
);
   generate
      if (GUARD) begin : g_window
         assign allow_o = (addr_i >= RAM_LO) && (addr_i <= RAM_HI);
      end else begin : g_open
         assign allow_o = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/lnk_msg_mover.sv
module lnk_msg_mover
   import lnk_msg_pkg::*;
#(
   parameter int unsigned BYTES_PER_WORD = 4,
   parameter int unsigned OVH_OUT        = 20,
   parameter int unsigned OVH_IN         = 18,
   parameter bit          WRITE_GUARD    = 1'b1,
   parameter logic [8*BYTES_PER_WORD-1:0] OUT_CHAN = 'h8000_0000,
   parameter logic [8*BYTES_PER_WORD-1:0] IN_CHAN  = 'h8000_0004,
   parameter logic [8*BYTES_PER_WORD-1:0] RAM_LO   = 'h80,
   parameter logic [8*BYTES_PER_WORD-1:0] RAM_HI   = 'hFFFF
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start_i,
   input  logic                        dir_out_i,
   input  logic [8*BYTES_PER_WORD-1:0] len_i,
   input  logic [8*BYTES_PER_WORD-1:0] chan_i,
   input  logic [8*BYTES_PER_WORD-1:0] base_i,
   output logic [8*BYTES_PER_WORD-1:0] mem_addr_o,
   input  logic [7:0]                  mem_rdata_i,
   output logic                        mem_we_o,
   output logic [7:0]                  mem_wdata_o,
   output logic                        tx_valid_o,
   input  logic                        tx_ready_i,
   output logic [7:0]                  tx_data_o,
   input  logic                        rx_valid_i,
   output logic                        rx_ready_o,
   input  logic [7:0]                  rx_data_i,
   output logic                        busy_o,
   output logic                        done_o,
   output logic                        err_o
);
   localparam int unsigned WORD_W = 8 * BYTES_PER_WORD;
   localparam int unsigned SEL_W  = $clog2(BYTES_PER_WORD);

   // elaboration-time parameter checks
   generate
      if (BYTES_PER_WORD < 2 || (BYTES_PER_WORD & (BYTES_PER_WORD - 1)) != 0) begin : g_bad_bpw
         $error("BYTES_PER_WORD must be a power of two, at least 2");
      end
      if (OUT_CHAN[SEL_W-1:0] != '0 || IN_CHAN[SEL_W-1:0] != '0) begin : g_bad_align
         $error("channel addresses must be word aligned");
      end
      if (OUT_CHAN == IN_CHAN) begin : g_bad_chan
         $error("channel addresses must differ");
      end
      if (RAM_LO > RAM_HI) begin : g_bad_ram
         $error("RAM window is empty");
      end
   endgenerate

   mover_state_e state_q;
   logic         is_out_q;
   logic         done_q;
   logic         err_q;
   logic         chan_ok;
   logic         accept;
   logic         reject;
   logic         empty;
   logic         min_met;
   logic         wr_allow;
   logic         moving;
   logic         hs_tx;
   logic         hs_rx;
   logic         finish;
   logic [WORD_W-1:0] cur_addr;

   assign moving  = (state_q == ST_MOVE);
   assign chan_ok = dir_out_i ? (chan_i == OUT_CHAN) : (chan_i == IN_CHAN);
   assign accept  = start_i && !moving && chan_ok;
   assign reject  = start_i && !moving && !chan_ok;

   assign tx_valid_o = moving && is_out_q && !empty;
   assign rx_ready_o = moving && !is_out_q && !empty;
   assign hs_tx      = tx_valid_o && tx_ready_i;
   assign hs_rx      = rx_ready_o && rx_valid_i;
   assign finish     = moving && empty && min_met;

   lnk_msg_cursor #(.WORD_W(WORD_W)) u_cursor (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (accept),
      .step_i  (hs_tx || hs_rx),
      .base_i  (base_i),
      .len_i   (len_i),
      .addr_o  (cur_addr),
      .empty_o (empty)
   );

   lnk_msg_pace #(
      .WORD_W (WORD_W),
      .SEL_W  (SEL_W),
      .OVH_OUT(OVH_OUT),
      .OVH_IN (OVH_IN)
   ) u_pace (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (accept),
      .run_i     (moving),
      .dir_out_i (dir_out_i),
      .len_i     (len_i),
      .min_met_o (min_met)
   );

   lnk_msg_wrgate #(
      .WORD_W(WORD_W),
      .GUARD (WRITE_GUARD),
      .RAM_LO(RAM_LO),
      .RAM_HI(RAM_HI)
   ) u_wrgate (
      .addr_i  (cur_addr),
      .allow_o (wr_allow)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         is_out_q <= 1'b0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         done_q <= finish;
         err_q  <= reject;
         if (accept) begin
            state_q  <= ST_MOVE;
            is_out_q <= dir_out_i;
         end else if (finish) begin
            state_q <= ST_IDLE;
         end
      end
   end

   assign mem_addr_o  = cur_addr;
   assign mem_we_o    = hs_rx && wr_allow;
   assign mem_wdata_o = rx_data_i;
   assign tx_data_o   = mem_rdata_i;
   assign busy_o      = moving;
   assign done_o      = done_q;
   assign err_o       = err_q;

   // R1: the two streams never run together
   p_one_stream_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_valid_o && rx_ready_o));
   // R2: a stalled byte is held with its address
   p_hold_tx_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(mem_addr_o)));
   // R4: done is a single-cycle pulse
   p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R4: done follows the end of a busy period
   p_done_after_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(busy_o) && !busy_o);
   // R5: writes stay inside the RAM window
   p_we_in_ram_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> (mem_addr_o >= RAM_LO) && (mem_addr_o <= RAM_HI));
   // R7: a refused start leaves the engine idle
   p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> !busy_o && !done_o && !tx_valid_o && !rx_ready_o);
   // R8: a start while busy changes nothing
   p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !finish) |=> busy_o && $stable(is_out_q));
   // R9: an idle engine moves nothing
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !tx_valid_o && !rx_ready_o && !mem_we_o);
endmodule

// File: tb/lnk_msg_mover_tb.sv
module lnk_msg_mover_tb;
   localparam logic [31:0] OUT_CH = 32'h8000_0000;
   localparam logic [31:0] IN_CH  = 32'h8000_0004;

   // vector: {dir_out, stall, len[7:0], base[7:0]}
   localparam int NVEC = 9;
   localparam logic [17:0] VEC [NVEC] = '{
      {1'b1, 1'b0, 8'd8,  8'h10},
      {1'b1, 1'b0, 8'd40, 8'h00},
      {1'b0, 1'b0, 8'd6,  8'h90},
      {1'b0, 1'b0, 8'd30, 8'hA0},
      {1'b0, 1'b0, 8'd8,  8'h7C},
      {1'b1, 1'b1, 8'd13, 8'h05},
      {1'b0, 1'b1, 8'd50, 8'hB0},
      {1'b1, 1'b0, 8'd0,  8'h20},
      {1'b0, 1'b0, 8'd0,  8'hC0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic dir_out_i = 1'b0;
   logic [31:0] len_i = '0;
   logic [31:0] chan_i = '0;
   logic [31:0] base_i = '0;
   logic [31:0] mem_addr_o;
   logic [7:0]  mem_rdata_i;
   logic mem_we_o;
   logic [7:0] mem_wdata_o;
   logic tx_valid_o;
   logic tx_ready_i = 1'b0;
   logic [7:0] tx_data_o;
   logic rx_valid_i = 1'b0;
   logic rx_ready_o;
   logic [7:0] rx_data_i = '0;
   logic busy_o, done_o, err_o;

   logic [7:0] mem [256];
   logic [7:0] got [256];
   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   always #2 clk = ~clk;

   assign mem_rdata_i = mem[mem_addr_o[7:0]];
   always @(posedge clk) if (mem_we_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;

   lnk_msg_mover #(
      .BYTES_PER_WORD(4), .OVH_OUT(20), .OVH_IN(18), .WRITE_GUARD(1'b1),
      .OUT_CHAN(OUT_CH), .IN_CHAN(IN_CH), .RAM_LO(32'h80), .RAM_HI(32'hFF)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_out_i(dir_out_i),
      .len_i(len_i), .chan_i(chan_i), .base_i(base_i),
      .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i),
      .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o),
      .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o),
      .rx_valid_i(rx_valid_i), .rx_ready_o(rx_ready_o), .rx_data_i(rx_data_i),
      .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
   );

   function automatic logic [7:0] init_byte(int a);
      return 8'(a * 7 + 3);
   endfunction
   function automatic logic [7:0] pat_byte(int i);
      return 8'((i * 5) ^ 8'hA5);
   endfunction
   function automatic int min_cost(bit out, int n);
      return 2 * ((n + 3) / 4) + (out ? 20 : 18);
   endfunction

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic fill_mem();
      for (int a = 0; a < 256; a++) mem[a] = init_byte(a);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 0, n_bad + 0);
         $finish;
      end
   end

   // Runs one accepted operation; poke injects a conflicting start at e==2.
   task automatic run_xfer(bit out, bit stall, int n, int base, bit poke);
      int e, idx, last, done_e, bad_data, extra;
      bit rdy;
      @(negedge clk);
      start_i = 1'b1; dir_out_i = out; len_i = n; base_i = base;
      chan_i = out ? OUT_CH : IN_CH;
      @(negedge clk);
      start_i = 1'b0;
      e = 0; idx = 0; last = 0; done_e = -1;
      while (e < 400) begin
         rdy = !stall || ((e % 3) != 1);
         if (out) begin
            tx_ready_i = rdy; #1;
            if (tx_valid_o && rdy) begin got[idx] = tx_data_o; idx++; last = e + 1; end
         end else begin
            rx_valid_i = rdy; rx_data_i = pat_byte(idx); #1;
            if (rx_ready_o && rdy) begin idx++; last = e + 1; end
         end
         if (poke && e == 2) begin
            start_i = 1'b1; dir_out_i = !out; len_i = 3;
            chan_i = out ? IN_CH : OUT_CH;
         end else begin
            start_i = 1'b0;
         end
         @(negedge clk);
         e++;
         if (done_o) begin done_e = e; break; end
      end
      start_i = 1'b0; tx_ready_i = 1'b0; rx_valid_i = 1'b0;
      check(idx == n, out ? "R2" : "R3", "byte handshakes", idx, n);
      check(done_e == ((min_cost(out, n) > last + 1) ? min_cost(out, n) : last + 1),
            n == 0 ? "R6" : "R4", "done edge", done_e,
            (min_cost(out, n) > last + 1) ? min_cost(out, n) : last + 1);
      bad_data = 0;
      if (out) begin
         for (int i = 0; i < n; i++) if (got[i] !== init_byte(base + i)) bad_data++;
         check(bad_data == 0, "R2", "sent byte mismatches", bad_data, 0);
      end else begin
         for (int i = 0; i <= n; i++) begin
            int a = base + i;
            logic [7:0] exp;
            exp = (i < n && a >= 128) ? pat_byte(i) : init_byte(a);
            if (mem[a] !== exp) bad_data++;
         end
         check(bad_data == 0, (base < 128) ? "R5" : "R3", "memory byte mismatches", bad_data, 0);
      end
      @(negedge clk);
      check(done_o == 1'b0, "R4", "done width", done_o, 0);
      extra = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (done_o || busy_o || tx_valid_o || rx_ready_o) extra++;
      end
      if (poke) check(extra == 0, "R8", "activity after ignored start", extra, 0);
   endtask

   initial begin
      int quiet;
      fill_mem();
      #10;
      @(negedge clk);
      check(busy_o == 0 && done_o == 0 && err_o == 0, "R9", "status in reset", busy_o + done_o + err_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(tx_valid_o == 0 && rx_ready_o == 0 && mem_we_o == 0, "R9", "streams after reset",
            tx_valid_o + rx_ready_o + mem_we_o, 0);

      for (int v = 0; v < NVEC; v++) begin
         fill_mem();
         run_xfer(VEC[v][17], VEC[v][16], int'(VEC[v][15:8]), int'(VEC[v][7:0]), 1'b0);
      end

      // R7: send requested on the input channel address
      fill_mem();
      @(negedge clk);
      start_i = 1'b1; dir_out_i = 1'b1; len_i = 4; base_i = 32'h10; chan_i = IN_CH;
      @(negedge clk);
      start_i = 1'b0;
      check(err_o == 1'b1, "R7", "error pulse", err_o, 1);
      check(busy_o == 1'b0, "R7", "busy after refusal", busy_o, 0);
      @(negedge clk);
      check(err_o == 1'b0, "R7", "error width", err_o, 0);
      quiet = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (done_o || tx_valid_o || busy_o) quiet++;
      end
      check(quiet == 0, "R7", "activity after refusal", quiet, 0);

      // R1: receive requested on the output channel address
      @(negedge clk);
      start_i = 1'b1; dir_out_i = 1'b0; len_i = 4; base_i = 32'h90; chan_i = OUT_CH;
      rx_valid_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check(err_o == 1'b1 && rx_ready_o == 1'b0, "R1", "mismatched receive refused", err_o, 1);
      rx_valid_i = 1'b0;
      check(mem[8'h90] === init_byte(8'h90), "R1", "memory after refusal", mem[8'h90], init_byte(8'h90));

      // R8: conflicting start while a send is in progress
      fill_mem();
      run_xfer(1'b1, 1'b0, 8, 32'h30, 1'b1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule